// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment-relative memory reference into a 20-bit physical address. It holds four 16-bit segment registers (extra, code, stack, data) and picks one of them from the kind of access being made. An optional override input can replace the default for some access kinds. The chosen segment value is scaled by sixteen, the 16-bit offset is added, and the sum is registered with a one-cycle valid pulse. The output also reports which segment was used.

A second, independent path builds 16-bit I/O port numbers. The port comes either from an 8-bit immediate, widened with zeros, or from a full 16-bit register value. The path flags ports that fall in the reserved window. Base-plus-index effective-address arithmetic is done upstream, and only the final offset is presented here.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, the code segment holds FFFFh and the extra, stack and data segments hold 0000h. `phys_addr`, `seg_used`, `io_addr` and `io_reserved` are zero, and both valid outputs are low. An instruction fetch at offset 0000h therefore yields FFFF0h.
- R2: `phys_addr` equals (segment × 16 + offset) modulo 2^20. Segment 12A4h with offset 0022h gives 12A62h, and segment FFFFh with offset FFFFh wraps to 0FFEFh.
- R3: Access kind 0 (instruction fetch) always uses the code segment, `seg_used` = 1. The override is ignored.
- R4: Access kind 1 (stack push/pop) always uses the stack segment, `seg_used` = 2. The override is ignored.
- R5: Access kind 2 (BP-based data) uses the stack segment unless `ovr_valid` is high, in which case `ovr_sel` selects the segment.
- R6: Access kind 3 (string destination through DI) always uses the extra segment, `seg_used` = 0. The override is ignored.
- R7: Access kind 4 (general data) uses the data segment, `seg_used` = 3, unless `ovr_valid` is high, in which case `ovr_sel` selects the segment. Kinds 5 to 7 behave as kind 4.
- R8: A request sampled high on a rising edge produces `phys_addr`, `seg_used` and a high `addr_valid` at that edge. `addr_valid` is high for exactly that one cycle, and `phys_addr` and `seg_used` hold their values while no request is made.
- R9: A segment write (`seg_we`, with index encoding 0 extra, 1 code, 2 stack, 3 data) takes effect for requests from the next cycle onward. A request in the same cycle as the write sees the old value.
- R10: When `io_use_imm` is high, `io_addr` is the 8-bit immediate with bits 15:8 zero. Otherwise `io_addr` is the full 16-bit register value. Results are registered on `io_req`, with `io_valid` high for one cycle.
- R11: `io_reserved` is high exactly when the registered port lies in 00F8h to 00FFh inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_we | input | 1 | Segment register write enable |
| seg_wsel | input | 2 | Segment to write (0 extra, 1 code, 2 stack, 3 data) |
| seg_wdata | input | 16 | Segment write value |
| req | input | 1 | Memory address request strobe |
| kind | input | 3 | Access kind (0 fetch, 1 stack, 2 BP data, 3 string destination, 4 data) |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment index |
| offset | input | 16 | Offset within the segment |
| io_req | input | 1 | I/O port request strobe |
| io_use_imm | input | 1 | Take the port from the immediate |
| io_imm | input | 8 | Immediate port number |
| io_reg | input | 16 | Register port number |
| phys_addr | output | 20 | Registered physical address |
| addr_valid | output | 1 | One-cycle pulse with a new address |
| seg_used | output | 2 | Segment index used for the address |
| io_addr | output | 16 | Registered I/O port address |
| io_valid | output | 1 | One-cycle pulse with a new port address |
| io_reserved | output | 1 | Port lies in the reserved window |

## Verification
The properties assume that `req` and `io_req` are ordinary single-cycle or back-to-back strobes. They also assume that the offset and kind inputs are meaningful only in a requested cycle, so checks compare each result against the inputs of the previous cycle only when a valid pulse is seen. The stimulus drives every input on the falling edge and holds it across exactly one rising edge, so each request is sampled once. Segment writes are issued alone, except in the case that deliberately overlaps a write and a request.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int NUM_SEGS = 4;
  localparam int SEL_W    = $clog2(NUM_SEGS);

  typedef enum logic [SEL_W-1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_idx_e;

  typedef enum logic [2:0] {
    ACC_FETCH  = 3'd0,
    ACC_STACK  = 3'd1,
    ACC_BPDATA = 3'd2,
    ACC_STRDST = 3'd3,
    ACC_DATA   = 3'd4
  } acc_kind_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter logic [SEG_W-1:0] RESET_CS = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  logic [SEG_W-1:0] wdata,
  input  logic [SEL_W-1:0] rsel,
  output logic [SEG_W-1:0] rdata
);
  logic [SEG_W-1:0] bank [NUM_SEGS];

  // Reset value per segment: only the code segment starts non-zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SEGS; i++)
        bank[i] <= (i == int'(SEG_CS)) ? RESET_CS : '0;
    end else if (we) begin
      bank[wsel] <= wdata;
    end
  end

  assign rdata = bank[rsel];
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
(
  input  logic [2:0]       kind,
  input  logic             ovr_valid,
  input  logic [SEL_W-1:0] ovr_sel,
  output logic [SEL_W-1:0] sel
);
  always_comb begin
    case (kind)
      ACC_FETCH:  sel = SEG_CS;
      ACC_STACK:  sel = SEG_SS;
      ACC_STRDST: sel = SEG_ES;
      ACC_BPDATA: sel = ovr_valid ? ovr_sel : SEG_SS;
      default:    sel = ovr_valid ? ovr_sel : SEG_DS;
    endcase
  end
endmodule

// File: rtl/io_port_map.sv
module io_port_map #(
  parameter int IO_W  = 16,
  parameter int IMM_W = 8,
  parameter logic [IO_W-1:0] RSV_LO = 16'h00F8,
  parameter logic [IO_W-1:0] RSV_HI = 16'h00FF
) (
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm,
  input  logic [IO_W-1:0]  regv,
  output logic [IO_W-1:0]  port,
  output logic             reserved
);
  localparam int PAD_W = IO_W - IMM_W;

  assign port     = use_imm ? {{PAD_W{1'b0}}, imm} : regv;
  assign reserved = (port >= RSV_LO) && (port <= RSV_HI);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  parameter int IO_W  = 16,
  parameter int IMM_W = 8,
  parameter logic [SEG_W-1:0] RESET_CS = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seg_we,
  input  logic [1:0]       seg_wsel,
  input  logic [SEG_W-1:0] seg_wdata,
  input  logic             req,
  input  logic [2:0]       kind,
  input  logic             ovr_valid,
  input  logic [1:0]       ovr_sel,
  input  logic [OFS_W-1:0] offset,
  input  logic             io_req,
  input  logic             io_use_imm,
  input  logic [IMM_W-1:0] io_imm,
  input  logic [IO_W-1:0]  io_reg,
  output logic [SEG_W+SHIFT-1:0] phys_addr,
  output logic             addr_valid,
  output logic [1:0]       seg_used,
  output logic [IO_W-1:0]  io_addr,
  output logic             io_valid,
  output logic             io_reserved
);
  localparam int ADDR_W = SEG_W + SHIFT;
  localparam int PAD_W  = ADDR_W - OFS_W;

  logic [SEL_W-1:0]  sel;
  logic [SEG_W-1:0]  seg_val;
  logic [ADDR_W-1:0] sum;
  logic [IO_W-1:0]   port;
  logic              port_rsv;

  seg_select u_sel (
    .kind      (kind),
    .ovr_valid (ovr_valid),
    .ovr_sel   (ovr_sel),
    .sel       (sel)
  );

  seg_regfile #(.SEG_W(SEG_W), .RESET_CS(RESET_CS)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (seg_we),
    .wsel  (seg_wsel),
    .wdata (seg_wdata),
    .rsel  (sel),
    .rdata (seg_val)
  );

  io_port_map #(.IO_W(IO_W), .IMM_W(IMM_W)) u_io (
    .use_imm  (io_use_imm),
    .imm      (io_imm),
    .regv     (io_reg),
    .port     (port),
    .reserved (port_rsv)
  );

  // Sum truncates to ADDR_W bits, so the carry out of the top bit is dropped.
  assign sum = {seg_val, {SHIFT{1'b0}}} + {{PAD_W{1'b0}}, offset};

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr   <= '0;
      addr_valid  <= 1'b0;
      seg_used    <= '0;
      io_addr     <= '0;
      io_valid    <= 1'b0;
      io_reserved <= 1'b0;
    end else begin
      addr_valid <= req;
      io_valid   <= io_req;
      if (req) begin
        phys_addr <= sum;
        seg_used  <= sel;
      end
      if (io_req) begin
        io_addr     <= port;
        io_reserved <= port_rsv;
      end
    end
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        req,
  input logic [2:0]  kind,
  input logic [15:0] offset,
  input logic        io_req,
  input logic        io_use_imm,
  input logic [19:0] phys_addr,
  input logic        addr_valid,
  input logic [1:0]  seg_used,
  input logic [15:0] io_addr,
  input logic        io_valid,
  input logic        io_reserved
);
  // R8
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> addr_valid);
  // R8
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> !addr_valid && $stable(phys_addr) && $stable(seg_used));
  // R2
  low_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> phys_addr[3:0] == $past(offset[3:0]));
  // R3
  fetch_code_chk: assert property (@(posedge clk) disable iff (rst)
    (req && kind == 3'd0) |=> seg_used == 2'd1);
  // R4
  stack_seg_chk: assert property (@(posedge clk) disable iff (rst)
    (req && kind == 3'd1) |=> seg_used == 2'd2);
  // R6
  string_extra_chk: assert property (@(posedge clk) disable iff (rst)
    (req && kind == 3'd3) |=> seg_used == 2'd0);
  // R10
  imm_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (io_req && io_use_imm) |=> io_valid && io_addr[15:8] == 8'h00);
  // R11
  reserved_window_chk: assert property (@(posedge clk) disable iff (rst)
    io_valid |-> io_reserved == (io_addr[15:3] == 13'h001F));
endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
  .clk(clk), .rst(rst), .req(req), .kind(kind), .offset(offset),
  .io_req(io_req), .io_use_imm(io_use_imm), .phys_addr(phys_addr),
  .addr_valid(addr_valid), .seg_used(seg_used), .io_addr(io_addr),
  .io_valid(io_valid), .io_reserved(io_reserved)
);

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seg_we = 1'b0;
  logic [1:0]  seg_wsel = '0;
  logic [15:0] seg_wdata = '0;
  logic        req = 1'b0;
  logic [2:0]  kind = '0;
  logic        ovr_valid = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic [15:0] offset = '0;
  logic        io_req = 1'b0;
  logic        io_use_imm = 1'b0;
  logic [7:0]  io_imm = '0;
  logic [15:0] io_reg = '0;
  logic [19:0] phys_addr;
  logic        addr_valid;
  logic [1:0]  seg_used;
  logic [15:0] io_addr;
  logic        io_valid;
  logic        io_reserved;

  int checks = 0;
  int errors = 0;
  logic [15:0] shadow [4];

  always #2.5 clk = ~clk;

  seg_addr_gen uut (
    .clk(clk), .rst(rst), .seg_we(seg_we), .seg_wsel(seg_wsel),
    .seg_wdata(seg_wdata), .req(req), .kind(kind), .ovr_valid(ovr_valid),
    .ovr_sel(ovr_sel), .offset(offset), .io_req(io_req),
    .io_use_imm(io_use_imm), .io_imm(io_imm), .io_reg(io_reg),
    .phys_addr(phys_addr), .addr_valid(addr_valid), .seg_used(seg_used),
    .io_addr(io_addr), .io_valid(io_valid), .io_reserved(io_reserved)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] expect_addr(logic [15:0] s, logic [15:0] o);
    logic [20:0] full = {1'b0, s, 4'h0} + {5'h00, o};
    return full[19:0];
  endfunction

  task automatic seg_write(logic [1:0] idx, logic [15:0] val);
    @(negedge clk);
    seg_we = 1'b1; seg_wsel = idx; seg_wdata = val;
    @(negedge clk);
    seg_we = 1'b0;
    shadow[idx] = val;
  endtask

  // Issue one request; on return the registered result is visible.
  task automatic issue(logic [2:0] k, logic ov, logic [1:0] os, logic [15:0] o);
    @(negedge clk);
    req = 1'b1; kind = k; ovr_valid = ov; ovr_sel = os; offset = o;
    @(negedge clk);
    req = 1'b0; ovr_valid = 1'b0;
  endtask

  task automatic expect_mem(string tag, logic [1:0] seg, logic [15:0] o);
    chk({tag, " seg"}, 32'(seg_used), 32'(seg));
    chk({tag, " addr"}, 32'(phys_addr), 32'(expect_addr(shadow[seg], o)));
    chk({tag, " valid"}, 32'(addr_valid), 32'd1);
  endtask

  task automatic io_issue(logic imm_mode, logic [7:0] im, logic [15:0] rv);
    @(negedge clk);
    io_req = 1'b1; io_use_imm = imm_mode; io_imm = im; io_reg = rv;
    @(negedge clk);
    io_req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 phys_addr", 32'(phys_addr), 32'd0);
    chk("R1 addr_valid", 32'(addr_valid), 32'd0);
    chk("R1 io_valid", 32'(io_valid), 32'd0);
    chk("R1 io_reserved", 32'(io_reserved), 32'd0);
    issue(3'd0, 1'b0, 2'd0, 16'h0000);
    chk("R1 first fetch", 32'(phys_addr), 32'h000FFFF0);
  endtask

  task automatic t_fetch;
    issue(3'd0, 1'b1, 2'd3, 16'h1234);
    expect_mem("R3 fetch ignores override", 2'd1, 16'h1234);
  endtask

  task automatic t_math;
    seg_write(2'd3, 16'h12A4);
    issue(3'd4, 1'b0, 2'd0, 16'h0022);
    chk("R2 12A4:0022", 32'(phys_addr), 32'h00012A62);
    seg_write(2'd3, 16'hFFFF);
    issue(3'd4, 1'b0, 2'd0, 16'hFFFF);
    chk("R2 wrap", 32'(phys_addr), 32'h0000FFEF);
  endtask

  task automatic t_stack;
    seg_write(2'd2, 16'h3000);
    issue(3'd1, 1'b1, 2'd3, 16'h0FFE);
    expect_mem("R4 stack ignores override", 2'd2, 16'h0FFE);
  endtask

  task automatic t_bp;
    seg_write(2'd0, 16'h5000);
    issue(3'd2, 1'b0, 2'd0, 16'h0040);
    expect_mem("R5 bp default", 2'd2, 16'h0040);
    issue(3'd2, 1'b1, 2'd0, 16'h0040);
    expect_mem("R5 bp override", 2'd0, 16'h0040);
  endtask

  task automatic t_string;
    issue(3'd3, 1'b1, 2'd3, 16'h0100);
    expect_mem("R6 string ignores override", 2'd0, 16'h0100);
  endtask

  task automatic t_data;
    seg_write(2'd3, 16'h0800);
    issue(3'd4, 1'b0, 2'd0, 16'h0010);
    expect_mem("R7 data default", 2'd3, 16'h0010);
    issue(3'd4, 1'b1, 2'd1, 16'h0010);
    expect_mem("R7 data override", 2'd1, 16'h0010);
    issue(3'd6, 1'b0, 2'd0, 16'h0020);
    expect_mem("R7 kind 6", 2'd3, 16'h0020);
  endtask

  task automatic t_pulse;
    logic [19:0] held;
    issue(3'd4, 1'b0, 2'd0, 16'h0ABC);
    held = phys_addr;
    offset = 16'h7777; kind = 3'd0;
    @(negedge clk);
    chk("R8 valid drops", 32'(addr_valid), 32'd0);
    chk("R8 address holds", 32'(phys_addr), 32'(held));
    chk("R8 segment holds", 32'(seg_used), 32'd3);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    seg_we = 1'b1; seg_wsel = 2'd3; seg_wdata = 16'h2000;
    req = 1'b1; kind = 3'd4; ovr_valid = 1'b0; offset = 16'h0004;
    @(negedge clk);
    seg_we = 1'b0; req = 1'b0;
    chk("R9 old value", 32'(phys_addr), 32'(expect_addr(shadow[3], 16'h0004)));
    shadow[3] = 16'h2000;
    issue(3'd4, 1'b0, 2'd0, 16'h0004);
    chk("R9 new value", 32'(phys_addr), 32'h00020004);
  endtask

  task automatic t_io;
    io_issue(1'b1, 8'hF8, 16'hAB00);
    chk("R10 imm zero-extend", 32'(io_addr), 32'h000000F8);
    chk("R10 io_valid", 32'(io_valid), 32'd1);
    chk("R11 imm F8 reserved", 32'(io_reserved), 32'd1);
    @(negedge clk);
    chk("R10 io_valid pulse", 32'(io_valid), 32'd0);
    io_issue(1'b0, 8'h00, 16'h10F8);
    chk("R10 register port", 32'(io_addr), 32'h000010F8);
    chk("R11 10F8 not reserved", 32'(io_reserved), 32'd0);
    io_issue(1'b0, 8'h00, 16'h00F7);
    chk("R11 F7 not reserved", 32'(io_reserved), 32'd0);
    io_issue(1'b0, 8'h00, 16'h00FF);
    chk("R11 FF reserved", 32'(io_reserved), 32'd1);
    io_issue(1'b0, 8'h00, 16'h0100);
    chk("R11 100 not reserved", 32'(io_reserved), 32'd0);
  endtask

  initial begin
    shadow[0] = 16'h0000; shadow[1] = 16'hFFFF;
    shadow[2] = 16'h0000; shadow[3] = 16'h0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_fetch;
    t_math;
    t_stack;
    t_bp;
    t_string;
    t_data;
    t_pulse;
    t_same_cycle;
    t_io;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule